// File: doc/BRIEF.md
# Configurable memory address decoder

This block turns a flat byte address from a system bus into the coordinates an SDRAM controller needs: which of four chips to drive, and the bank, row and column inside that chip. The chip is chosen by a masked compare of the top eight address bits against per-chip match and mask values. Three global fields set how many column, row and bank bits the devices have. A per-chip ordering bit selects whether the bank bits sit between the column and row bits, or above the row bits.

The low address bits that address bytes within one memory word are dropped before the column is taken. The decode is combinational. By default, one register stage follows it, so results appear one clock after the address. When no chip claims an address, the block still produces a decode and raises a flag. The controller can use that flag or ignore it.

Top module: `addr_map_dec`

## Requirements
- R1: Chip c matches when ((addr[31:24] XOR match_c) AND mask_c) is zero. A mask bit of 1 means the bit is compared; a mask bit of 0 means it is ignored. chip_match and chip_mask hold chip c in bits [8c+7:8c]. `chip_idx` gives the selected chip as a binary number.
- R2: If no chip matches, `chip_idx` is 0 and `nomatch` is 1. Whenever at least one chip matches, `nomatch` is 0.
- R3: When several chips match, the one with the lowest index is selected.
- R4: The column is taken from addr starting at bit 2, the byte offset. Its width is 8 + col_cfg bits. A col_cfg value above 4 acts as 4, giving 12 bits. Output bits above the width are 0.
- R5: The row width is 11 + row_cfg bits. A row_cfg value above 5 acts as 5, giving 16 bits. Row output bits above the width are 0.
- R6: The bank has 2 bits when bank_cfg is 0 and 3 bits otherwise. Bank output bits above the width are 0.
- R7: When a chip's order bit is 0, the bank bits sit directly above the column and the row sits above the bank. When the order bit is 1, the row sits directly above the column and the bank sits above the row.
- R8: The order bit used is the one of the selected chip. On no match, this is chip 0's bit. chip_order bit c belongs to chip c.
- R9: All outputs reflect the inputs present at the previous rising clock edge. An active-low asynchronous reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 32 | Byte address to decode |
| chip_match | input | 32 | Match value, 8 bits per chip |
| chip_mask | input | 32 | Compare mask, 8 bits per chip, 1 = compared |
| chip_order | input | 4 | Per-chip order bit, 1 = bank above row |
| col_cfg | input | 3 | Column width code |
| row_cfg | input | 3 | Row width code |
| bank_cfg | input | 3 | Bank width code |
| chip_idx | output | 2 | Selected chip |
| nomatch | output | 1 | No chip claimed the address |
| bank | output | 3 | Bank number |
| row | output | 16 | Row number |
| col | output | 12 | Column number |

## Verification
On every cycle, the assertions check the following:
- The selected chip really matches its masked compare.
- A missing match forces chip 0.
- The column, row and bank values never exceed the widths that the current configuration allows.
- The register stage delivers exactly the previous cycle's decode.

Some behaviour only the bench scenarios can show. Lowest-index priority for overlapping chips needs them. So does the exact bit placement under both orders and the clamping of oversized width codes. The use of chip 0's order on a miss also needs a scenario, and each of these is compared against hand-computed field values.

// File: rtl/adm_pkg.sv
package adm_pkg;

    localparam int COL_MIN  = 8;
    localparam int COL_W    = 12;
    localparam int ROW_MIN  = 11;
    localparam int ROW_W    = 16;
    localparam int BANK_W   = 3;
    localparam int CBITS_W  = $clog2(COL_W + 1);
    localparam int RBITS_W  = $clog2(ROW_W + 1);
    localparam int BBITS_W  = $clog2(BANK_W + 1);

    // Column width from its code, codes beyond the top width clamp.
    function automatic logic [CBITS_W-1:0] col_bits(input logic [2:0] code);
        if (int'(code) > COL_W - COL_MIN)
            return CBITS_W'(COL_W);
        return CBITS_W'(COL_MIN + int'(code));
    endfunction

    // Row width from its code, codes beyond the top width clamp.
    function automatic logic [RBITS_W-1:0] row_bits(input logic [2:0] code);
        if (int'(code) > ROW_W - ROW_MIN)
            return RBITS_W'(ROW_W);
        return RBITS_W'(ROW_MIN + int'(code));
    endfunction

    // Bank width: zero code gives one bit less than the widest bank.
    function automatic logic [BBITS_W-1:0] bank_bits(input logic [2:0] code);
        return (code == 3'd0) ? BBITS_W'(BANK_W - 1) : BBITS_W'(BANK_W);
    endfunction

endpackage

// File: rtl/adm_chip_pick.sv
module adm_chip_pick #(
    parameter int NCHIP = 4,
    parameter int SEL_W = 8,
    parameter int IDX_W = $clog2(NCHIP)
) (
    input  logic [SEL_W-1:0]       top_bits,
    input  logic [NCHIP*SEL_W-1:0] match_vals,
    input  logic [NCHIP*SEL_W-1:0] mask_vals,
    output logic [IDX_W-1:0]       pick_idx,
    output logic                   pick_none
);

    logic [NCHIP-1:0] hit;

    for (genvar g = 0; g < NCHIP; g++) begin : g_cmp
        assign hit[g] = (((top_bits ^ match_vals[g*SEL_W +: SEL_W])
                          & mask_vals[g*SEL_W +: SEL_W]) == '0);
    end

    // Highest index scanned first so the lowest hit is kept.
    always_comb begin
        pick_idx = '0;
        for (int i = NCHIP - 1; i >= 0; i--) begin
            if (hit[i]) pick_idx = IDX_W'(i);
        end
        pick_none = (hit == '0);
    end

endmodule

// File: rtl/adm_field_cut.sv
module adm_field_cut
    import adm_pkg::*;
#(
    parameter int WORD_W = 30
) (
    input  logic [WORD_W-1:0]  word,
    input  logic [CBITS_W-1:0] cbits,
    input  logic [RBITS_W-1:0] rbits,
    input  logic [BBITS_W-1:0] bbits,
    input  logic               bank_high,
    output logic [COL_W-1:0]   col_o,
    output logic [ROW_W-1:0]   row_o,
    output logic [BANK_W-1:0]  bank_o
);

    logic [COL_W-1:0]  cmask;
    logic [ROW_W-1:0]  rmask;
    logic [BANK_W-1:0] bmask;
    logic [WORD_W-1:0] above;

    always_comb begin
        cmask  = ~({COL_W{1'b1}}  << cbits);
        rmask  = ~({ROW_W{1'b1}}  << rbits);
        bmask  = ~({BANK_W{1'b1}} << bbits);
        above  = word >> cbits;
        col_o  = COL_W'(word) & cmask;
        if (bank_high) begin
            row_o  = ROW_W'(above) & rmask;
            bank_o = BANK_W'(above >> rbits) & bmask;
        end else begin
            bank_o = BANK_W'(above) & bmask;
            row_o  = ROW_W'(above >> bbits) & rmask;
        end
    end

endmodule

// File: rtl/addr_map_dec.sv
module addr_map_dec
    import adm_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NCHIP    = 4,
    parameter int SEL_W    = 8,
    parameter int BYTE_OFF = 2,
    parameter bit REG_OUT  = 1'b1,
    localparam int IDX_W   = $clog2(NCHIP),
    localparam int WORD_W  = ADDR_W - BYTE_OFF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NCHIP*SEL_W-1:0] chip_match,
    input  logic [NCHIP*SEL_W-1:0] chip_mask,
    input  logic [NCHIP-1:0]       chip_order,
    input  logic [2:0]             col_cfg,
    input  logic [2:0]             row_cfg,
    input  logic [2:0]             bank_cfg,
    output logic [IDX_W-1:0]       chip_idx,
    output logic                   nomatch,
    output logic [BANK_W-1:0]      bank,
    output logic [ROW_W-1:0]       row,
    output logic [COL_W-1:0]       col
);

    typedef struct packed {
        logic [IDX_W-1:0]  chip;
        logic              miss;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } dec_t;

    dec_t dec_d, dec_q;

    logic [IDX_W-1:0]   pick_idx;
    logic               pick_none;
    logic [COL_W-1:0]   cut_col;
    logic [ROW_W-1:0]   cut_row;
    logic [BANK_W-1:0]  cut_bank;
    logic [CBITS_W-1:0] cbits;
    logic [RBITS_W-1:0] rbits;
    logic [BBITS_W-1:0] bbits;
    logic [WORD_W-1:0]  word;

    assign cbits = col_bits(col_cfg);
    assign rbits = row_bits(row_cfg);
    assign bbits = bank_bits(bank_cfg);
    assign word  = WORD_W'(addr >> BYTE_OFF);

    adm_chip_pick #(.NCHIP(NCHIP), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_pick (
        .top_bits   (addr[ADDR_W-1 -: SEL_W]),
        .match_vals (chip_match),
        .mask_vals  (chip_mask),
        .pick_idx   (pick_idx),
        .pick_none  (pick_none)
    );

    adm_field_cut #(.WORD_W(WORD_W)) u_cut (
        .word      (word),
        .cbits     (cbits),
        .rbits     (rbits),
        .bbits     (bbits),
        .bank_high (chip_order[pick_idx]),
        .col_o     (cut_col),
        .row_o     (cut_row),
        .bank_o    (cut_bank)
    );

    always_comb begin
        dec_d      = '0;
        dec_d.chip = pick_idx;
        dec_d.miss = pick_none;
        dec_d.bank = cut_bank;
        dec_d.row  = cut_row;
        dec_d.col  = cut_col;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dec_q <= '0;
            else        dec_q <= dec_d;
        end

        // R9
        reg_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (dec_q == $past(dec_d)));
    end else begin : g_comb
        assign dec_q = dec_d;
    end

    assign chip_idx = dec_q.chip;
    assign nomatch  = dec_q.miss;
    assign bank     = dec_q.bank;
    assign row      = dec_q.row;
    assign col      = dec_q.col;

    // R1
    chip_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_d.miss |-> (((addr[ADDR_W-1 -: SEL_W] ^ chip_match[dec_d.chip*SEL_W +: SEL_W])
                          & chip_mask[dec_d.chip*SEL_W +: SEL_W]) == '0));

    // R2
    miss_chip0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_d.miss |-> (dec_d.chip == '0));

    // R4
    col_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_d.col >> cbits) == '0);

    // R5
    row_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_d.row >> rbits) == '0);

    // R6
    bank_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_d.bank >> bbits) == '0);

endmodule

// File: tb/sim_addr_map_dec.sv
module sim_addr_map_dec;

    localparam int PERIOD = 10;
    localparam int NVEC   = 12;

    typedef struct packed {
        logic [31:0] a;
        logic [2:0]  cc;
        logic [2:0]  rc;
        logic [2:0]  bc;
        logic [3:0]  ord;
        logic [1:0]  chip;
        logic        nm;
        logic [2:0]  bank;
        logic [15:0] row;
        logic [11:0] col;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        // R1 zero address on chip 0
        '{32'h0000_0000, 3'd0, 3'd0, 3'd0, 4'b0000, 2'd0, 1'b0, 3'd0, 16'h0000, 12'h000, 4'd1},
        // R7 order 0: bank above column
        '{32'h4015_5AAC, 3'd0, 3'd0, 3'd0, 4'b0000, 2'd1, 1'b0, 3'd2, 16'h0155, 12'h0AB, 4'd7},
        // R7 order 1: row above column
        '{32'h4015_5AAC, 3'd0, 3'd0, 3'd0, 4'b0010, 2'd1, 1'b0, 3'd0, 16'h0556, 12'h0AB, 4'd7},
        // R4 widest column, widest row, three bank bits
        '{32'h3FFF_FFFF, 3'd4, 3'd5, 3'd1, 4'b0000, 2'd0, 1'b0, 3'd7, 16'h1FFF, 12'hFFF, 4'd4},
        // R5 oversized codes clamp to the same result
        '{32'h3FFF_FFFF, 3'd7, 3'd7, 3'd5, 4'b0000, 2'd0, 1'b0, 3'd7, 16'h1FFF, 12'hFFF, 4'd5},
        // R3 chips 2 and 3 both match, 2 wins
        '{32'h8400_0000, 3'd0, 3'd0, 3'd0, 4'b0000, 2'd2, 1'b0, 3'd0, 16'h0000, 12'h000, 4'd3},
        // R1 only chip 3 matches
        '{32'h9000_0000, 3'd0, 3'd0, 3'd0, 4'b0000, 2'd3, 1'b0, 3'd0, 16'h0000, 12'h000, 4'd1},
        // R2 no chip matches, chip 0 order used
        '{32'hC000_1234, 3'd0, 3'd0, 3'd0, 4'b1110, 2'd0, 1'b1, 3'd0, 16'h0001, 12'h08D, 4'd2},
        // R8 chip 0 order 1, mid widths
        '{32'h1234_5678, 3'd2, 3'd3, 3'd0, 4'b0001, 2'd0, 1'b0, 3'd0, 16'h2345, 12'h19E, 4'd8},
        // R8 chip 0 order 0, same address
        '{32'h1234_5678, 3'd2, 3'd3, 3'd0, 4'b1110, 2'd0, 1'b0, 3'd1, 16'h08D1, 12'h19E, 4'd8},
        // R6 three bank bits on chip 1 order 1
        '{32'h7FFF_FFFF, 3'd1, 3'd1, 3'd1, 4'b0010, 2'd1, 1'b0, 3'd7, 16'h0FFF, 12'h1FF, 4'd6},
        // R6 two bank bits on chip 1 order 1
        '{32'h7FFF_FFFF, 3'd1, 3'd1, 3'd0, 4'b0010, 2'd1, 1'b0, 3'd3, 16'h0FFF, 12'h1FF, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] chip_match = {8'h80, 8'h80, 8'h40, 8'h00};
    logic [31:0] chip_mask  = {8'hE0, 8'hF0, 8'hC0, 8'hC0};
    logic [3:0]  chip_order = '0;
    logic [2:0]  col_cfg = '0, row_cfg = '0, bank_cfg = '0;
    logic [1:0]  chip_idx;
    logic        nomatch;
    logic [2:0]  bank;
    logic [15:0] row;
    logic [11:0] col;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    addr_map_dec u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .chip_match(chip_match), .chip_mask(chip_mask), .chip_order(chip_order),
        .col_cfg(col_cfg), .row_cfg(row_cfg), .bank_cfg(bank_cfg),
        .chip_idx(chip_idx), .nomatch(nomatch), .bank(bank), .row(row), .col(col)
    );

    task automatic apply(input vec_t v);
        addr = v.a; col_cfg = v.cc; row_cfg = v.rc; bank_cfg = v.bc; chip_order = v.ord;
    endtask

    task automatic check_out(input string tag, input vec_t v);
        total++;
        if (chip_idx !== v.chip || nomatch !== v.nm || bank !== v.bank ||
            row !== v.row || col !== v.col) begin
            bad++;
            $display("FAIL %s: got chip=%0d nm=%0b bank=%0d row=%h col=%h exp chip=%0d nm=%0b bank=%0d row=%h col=%h",
                     tag, chip_idx, nomatch, bank, row, col, v.chip, v.nm, v.bank, v.row, v.col);
        end
    endtask

    initial begin
        vec_t zero;
        zero = '0;
        // R9 reset state with live inputs
        apply(VECS[1]);
        repeat (3) @(negedge clk);
        check_out("R9 reset", zero);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i]);
            @(negedge clk);
            check_out($sformatf("vector %0d R%0d", i, VECS[i].req), VECS[i]);
        end

        // R9 one clock latency: old value held until the edge
        apply(VECS[10]);
        @(negedge clk);
        apply(VECS[7]);
        #1;
        check_out("R9 hold before edge", VECS[10]);
        @(negedge clk);
        check_out("R9 after edge", VECS[7]);

        // R2 flag drops again on a matching address
        apply(VECS[6]);
        @(negedge clk);
        check_out("R2 flag clear", VECS[6]);

        // R9 asynchronous reset mid-run
        rst_n = 1'b0;
        #1;
        check_out("R9 async reset", zero);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R9 after reset", VECS[6]);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule